// File: doc/BRIEF.md
# Asynchronous SRAM write sequencer

This block sits between a clocked host and the pins of an asynchronous static RAM. The host presents an address and a data word with a one-cycle request. The block latches them and plays out a full write cycle on the memory pins: address, data, active-low chip enable, active-low write enable and active-low output enable. Every edge is placed by a small down-counter. Each nanosecond minimum is converted at elaboration into a whole number of clock cycles: the minimum divided by the clock period, rounded up, and never less than one cycle.

A parameter selects which strobe ends the write. In the write-enable style, chip enable falls first and write enable pulses inside it. In the chip-enable style, write enable falls first and chip enable pulses inside it, so the memory never turns on its outputs. Output enable stays inactive throughout. The data pins are driven only while both strobes are low and during the hold phase that follows. The host sees busy while a cycle is in flight and a one-cycle done pulse when it ends.

Top module: `sram_wr_seq`

## Requirements
- R1: During reset the chip enable, write enable and output enable pins are high, the data drive enable is low, and busy and done are low.
- R2: A request taken while busy is low appears at the address pins one cycle later, and busy is high in that cycle.
- R3: With the write-enable style (CE_CTRL=0) and the default 4 ns clock with a 25 ns grade, chip enable falls alone for 1 cycle. Both strobes are then low for 5 cycles. Write enable rises first, and chip enable stays low for 1 more cycle.
- R4: With the chip-enable style (CE_CTRL=1), write enable falls alone first. Chip enable then falls and is the strobe that rises to end the write, while write enable stays low for the hold cycle.
- R5: The data drive enable is high exactly in the cycles where both strobes are low and in the hold cycle after them. In those cycles the data pins carry the word latched at the request. The drive enable is low whenever both strobes are high.
- R6: The output enable pin is high in every cycle.
- R7: The address pins hold the latched address for the whole cycle, and busy lasts the cycle count of the write-cycle minimum. That is 7 cycles for the 25 ns grade at 4 ns.
- R8: A request made while busy is high is ignored. The address and data in flight do not change, and no extra cycle follows.
- R9: Done is high for exactly one cycle, in the first cycle with busy low. A request made in that cycle is accepted at once.
- R10: For a 45 ns grade (strobes and address setup of 30 ns, data setup of 15 ns, 4 ns clock), the strobe overlap is 8 cycles. Two idle recovery cycles are added so that busy lasts 12 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Write request, one cycle |
| addr_i | input | AW | Write address, sampled with req_i |
| data_i | input | DW | Write data, sampled with req_i |
| busy_o | output | 1 | Write cycle in flight |
| done_o | output | 1 | One-cycle pulse at the end of a write |
| sram_addr_o | output | AW | Memory address pins |
| sram_dq_o | output | DW | Memory data pins (value) |
| sram_dq_oe_o | output | 1 | Data pad drive enable; low means high-impedance |
| sram_ce_no | output | 1 | Chip enable, active low |
| sram_we_no | output | 1 | Write enable, active low |
| sram_oe_no | output | 1 | Output enable, active low |

## Verification
A wrong phase or a mis-loaded counter shows at the pins within the same write. The lone-strobe setup, the overlap or the hold phase would then come out a cycle long or short, or busy would not cover the full cycle count. Done would also come out of place in that case. A bad latch or a missed busy gate shows as a changed address or data word while the strobes are low, in the same cycle. A wrong drive window shows as the drive enable being high while both strobes are high. Both strobe styles and two speed grades are run, so the recovery phase is exercised and so is the case where that phase is skipped.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_REC
  } phase_e;

  // ceil(ns / clk_ns), at least one cycle
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wr_timer.sv
module sram_wr_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  a_r3_timer_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/sram_wr_fsm.sv
module sram_wr_fsm
  import sram_wr_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int N_AS  = 1,
  parameter int N_ST  = 5,
  parameter int N_HD  = 1,
  parameter int N_REC = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             zero_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output phase_e           phase_d_o,
  output logic             accept_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int LV_REC = (N_REC > 0) ? N_REC - 1 : 0;

  phase_e ph_q, ph_d;
  logic   done_q;

  always_comb begin
    ph_d       = ph_q;
    load_o     = 1'b0;
    load_val_o = '0;
    case (ph_q)
      PH_IDLE: if (req_i) begin
        ph_d = PH_SETUP; load_o = 1'b1; load_val_o = CNT_W'(N_AS - 1);
      end
      PH_SETUP: if (zero_i) begin
        ph_d = PH_STROBE; load_o = 1'b1; load_val_o = CNT_W'(N_ST - 1);
      end
      PH_STROBE: if (zero_i) begin
        ph_d = PH_HOLD; load_o = 1'b1; load_val_o = CNT_W'(N_HD - 1);
      end
      PH_HOLD: if (zero_i) begin
        if (N_REC > 0) begin
          ph_d = PH_REC; load_o = 1'b1; load_val_o = CNT_W'(LV_REC);
        end else begin
          ph_d = PH_IDLE;
        end
      end
      PH_REC: if (zero_i) ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      done_q <= (ph_q != PH_IDLE) && (ph_d == PH_IDLE);
    end
  end

  assign phase_d_o = ph_d;
  assign accept_o  = (ph_q == PH_IDLE) && req_i;
  assign busy_o    = (ph_q != PH_IDLE);
  assign done_o    = done_q;

  a_r2_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> busy_o);
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: rtl/sram_wr_pins.sv
module sram_wr_pins
  import sram_wr_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter bit CE_CTRL = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  phase_e        phase_d_i,
  output logic [AW-1:0] sram_addr_o,
  output logic [DW-1:0] sram_dq_o,
  output logic          sram_dq_oe_o,
  output logic          sram_ce_no,
  output logic          sram_we_no
);
  logic lead_d, end_d, dq_oe_d, ce_d, we_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic ce_q, we_q, dq_oe_q;

  // lead strobe opens the cycle; end strobe closes the write
  assign lead_d  = !(phase_d_i inside {PH_SETUP, PH_STROBE, PH_HOLD});
  assign end_d   = (phase_d_i != PH_STROBE);
  assign dq_oe_d = (phase_d_i inside {PH_STROBE, PH_HOLD});

  if (CE_CTRL) begin : g_ce_ends
    assign ce_d = end_d;
    assign we_d = lead_d;
  end else begin : g_we_ends
    assign ce_d = lead_d;
    assign we_d = end_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      data_q  <= '0;
      ce_q    <= 1'b1;
      we_q    <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      if (accept_i) begin
        addr_q <= addr_i;
        data_q <= data_i;
      end
      ce_q    <= ce_d;
      we_q    <= we_d;
      dq_oe_q <= dq_oe_d;
    end
  end

  assign sram_addr_o  = addr_q;
  assign sram_dq_o    = data_q;
  assign sram_dq_oe_o = dq_oe_q;
  assign sram_ce_no   = ce_q;
  assign sram_we_no   = we_q;

  a_r7_addr_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_ce_no && !sram_we_no) |=> $stable(sram_addr_o));
  a_r5_data_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_dq_oe_o && $past(sram_dq_oe_o)) |-> $stable(sram_dq_o));
endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter bit CE_CTRL = 1'b0,
  parameter int CLK_NS  = 4,
  parameter int T_WC_NS = 25,
  parameter int T_WP_NS = 20,
  parameter int T_CW_NS = 20,
  parameter int T_DW_NS = 10,
  parameter int T_AW_NS = 20,
  parameter int T_AS_NS = 0,
  parameter int T_WR_NS = 0,
  parameter int T_DH_NS = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] sram_addr_o,
  output logic [DW-1:0] sram_dq_o,
  output logic          sram_dq_oe_o,
  output logic          sram_ce_no,
  output logic          sram_we_no,
  output logic          sram_oe_no
);
  localparam int N_AS   = ns_to_cyc(T_AS_NS, CLK_NS);
  localparam int N_ST   = imax(imax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_CW_NS, CLK_NS)),
                               imax(ns_to_cyc(T_AW_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS)));
  localparam int N_HD   = imax(ns_to_cyc(T_WR_NS, CLK_NS), ns_to_cyc(T_DH_NS, CLK_NS));
  localparam int N_WC   = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int N_USED = N_AS + N_ST + N_HD;
  localparam int N_REC  = (N_WC > N_USED) ? N_WC - N_USED : 0;
  localparam int N_MAX  = imax(imax(N_AS, N_ST), imax(N_HD, N_REC));
  localparam int CNT_W  = $clog2(N_MAX + 1);
  localparam int SW     = $clog2(N_USED + N_REC + 1) + 1;

  logic             load, zero, accept;
  logic [CNT_W-1:0] load_val;
  phase_e           phase_d;

  sram_wr_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(load_val), .zero_o(zero)
  );

  sram_wr_fsm #(
    .CNT_W(CNT_W), .N_AS(N_AS), .N_ST(N_ST), .N_HD(N_HD), .N_REC(N_REC)
  ) u_fsm (
    .clk_i, .rst_ni, .req_i, .zero_i(zero),
    .load_o(load), .load_val_o(load_val), .phase_d_o(phase_d),
    .accept_o(accept), .busy_o, .done_o
  );

  sram_wr_pins #(.AW(AW), .DW(DW), .CE_CTRL(CE_CTRL)) u_pins (
    .clk_i, .rst_ni, .accept_i(accept), .addr_i, .data_i,
    .phase_d_i(phase_d), .sram_addr_o, .sram_dq_o, .sram_dq_oe_o,
    .sram_ce_no, .sram_we_no
  );

  // memory never drives the bus during a write
  assign sram_oe_no = 1'b1;

  // window counters for the checks below
  logic [SW-1:0] run_q, cyc_q;
  logic          both_low, end_n;
  assign both_low = !sram_ce_no && !sram_we_no;
  assign end_n    = CE_CTRL ? sram_ce_no : sram_we_no;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      cyc_q <= '0;
    end else begin
      run_q <= both_low ? run_q + 1'b1 : '0;
      cyc_q <= busy_o   ? cyc_q + 1'b1 : '0;
    end
  end

  a_r3_strobe_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!both_low && run_q != '0) |-> (run_q == SW'(N_ST)));
  a_r7_cycle_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cyc_q >= SW'(N_WC)));
  a_r8_busy_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(sram_addr_o));
  a_r4_end_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (both_low && !$past(both_low)) |=> !end_n);
endmodule

// File: tb/sram_wr_seq_bench.sv
`timescale 1ns/1ps

module sram_wr_seq_mon #(
  parameter bit    CE_CTRL  = 1'b0,
  parameter int    AW       = 16,
  parameter int    DW       = 8,
  parameter int    EXP_AS   = 1,
  parameter int    EXP_ST   = 5,
  parameter int    EXP_HD   = 1,
  parameter int    EXP_BUSY = 7,
  parameter string TAG      = "we"
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          busy_i,
  input  logic          done_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] dq_i,
  input  logic          dq_oe_i,
  input  logic          ce_n_i,
  input  logic          we_n_i,
  input  logic          oe_n_i,
  output int            checks_o,
  output int            bad_o,
  output int            pending_o
);
  logic [AW+DW-1:0] exp_q[$];
  int n_set = 0, n_st = 0, n_hd = 0, n_busy = 0;
  int checks = 0, bad = 0;
  bit seen = 0;
  string sty;

  assign checks_o  = checks;
  assign bad_o     = bad;
  assign pending_o = exp_q.size();
  assign sty       = CE_CTRL ? "R4" : "R3";

  function automatic void push(input logic [AW-1:0] a, input logic [DW-1:0] d);
    exp_q.push_back({a, d});
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL [%s] %s act=%0d exp=%0d at %0t", TAG, req, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    logic end_n, lead_n;
    end_n  = CE_CTRL ? ce_n_i : we_n_i;
    lead_n = CE_CTRL ? we_n_i : ce_n_i;
    if (rst_ni) begin
      chk(oe_n_i == 1'b1, "R6 output enable high", int'(oe_n_i), 1);
      if (ce_n_i && we_n_i) chk(!dq_oe_i, "R5 released when idle", int'(dq_oe_i), 0);
      if (busy_i) begin
        n_busy++;
        if (exp_q.size() == 0) chk(1'b0, "R8 cycle with no request", 1, 0);
        else chk(addr_i == exp_q[0][DW +: AW], "R7 address held", int'(addr_i),
                 int'(exp_q[0][DW +: AW]));
      end
      if (!lead_n && end_n && !seen) n_set++;
      if (!lead_n && !end_n) begin
        n_st++;
        seen = 1'b1;
        chk(dq_oe_i, "R5 driven in strobe", int'(dq_oe_i), 1);
        if (exp_q.size() != 0)
          chk(dq_i == exp_q[0][DW-1:0], "R5 data value", int'(dq_i), int'(exp_q[0][DW-1:0]));
      end
      if (!lead_n && end_n && seen) begin
        n_hd++;
        chk(dq_oe_i, "R5 driven in hold", int'(dq_oe_i), 1);
      end
      if (lead_n && !end_n) chk(1'b0, {sty, " end strobe alone"}, 0, 1);
      if (done_i) begin
        chk(!busy_i, "R9 done with busy low", int'(busy_i), 0);
        chk(n_set == EXP_AS, {sty, " lead strobe setup"}, n_set, EXP_AS);
        chk(n_st == EXP_ST, {sty, " overlap length (R10)"}, n_st, EXP_ST);
        chk(n_hd == EXP_HD, {sty, " hold length"}, n_hd, EXP_HD);
        chk(n_busy == EXP_BUSY, "R7 busy length (R10)", n_busy, EXP_BUSY);
        if (exp_q.size() != 0) void'(exp_q.pop_front());
        n_set = 0; n_st = 0; n_hd = 0; n_busy = 0; seen = 1'b0;
      end
    end
  end
endmodule

module sram_wr_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req[2];
  logic [15:0] addr[2];
  logic [7:0]  data[2];
  logic        busy[2], done[2], dq_oe[2], ce_n[2], we_n[2], oe_n[2];
  logic [15:0] sa[2];
  logic [7:0]  dq[2];
  int ca, ba, pa, cb, bb, pb;
  int checks = 0, bad = 0;
  bit finished = 0;

  sram_wr_seq u_sram_wr_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req[0]), .addr_i(addr[0]), .data_i(data[0]),
    .busy_o(busy[0]), .done_o(done[0]), .sram_addr_o(sa[0]), .sram_dq_o(dq[0]),
    .sram_dq_oe_o(dq_oe[0]), .sram_ce_no(ce_n[0]), .sram_we_no(we_n[0]), .sram_oe_no(oe_n[0])
  );

  sram_wr_seq #(
    .CE_CTRL(1'b1), .T_WC_NS(45), .T_WP_NS(30), .T_CW_NS(30), .T_DW_NS(15), .T_AW_NS(30)
  ) u_sram_wr_seq_ce (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req[1]), .addr_i(addr[1]), .data_i(data[1]),
    .busy_o(busy[1]), .done_o(done[1]), .sram_addr_o(sa[1]), .sram_dq_o(dq[1]),
    .sram_dq_oe_o(dq_oe[1]), .sram_ce_no(ce_n[1]), .sram_we_no(we_n[1]), .sram_oe_no(oe_n[1])
  );

  sram_wr_seq_mon #(.CE_CTRL(1'b0), .EXP_AS(1), .EXP_ST(5), .EXP_HD(1), .EXP_BUSY(7),
                    .TAG("we")) u_mon_a (
    .clk_i(clk), .rst_ni(rst_n), .busy_i(busy[0]), .done_i(done[0]), .addr_i(sa[0]),
    .dq_i(dq[0]), .dq_oe_i(dq_oe[0]), .ce_n_i(ce_n[0]), .we_n_i(we_n[0]), .oe_n_i(oe_n[0]),
    .checks_o(ca), .bad_o(ba), .pending_o(pa)
  );

  sram_wr_seq_mon #(.CE_CTRL(1'b1), .EXP_AS(1), .EXP_ST(8), .EXP_HD(1), .EXP_BUSY(12),
                    .TAG("ce")) u_mon_b (
    .clk_i(clk), .rst_ni(rst_n), .busy_i(busy[1]), .done_i(done[1]), .addr_i(sa[1]),
    .dq_i(dq[1]), .dq_oe_i(dq_oe[1]), .ce_n_i(ce_n[1]), .we_n_i(we_n[1]), .oe_n_i(oe_n[1]),
    .checks_o(cb), .bad_o(bb), .pending_o(pb)
  );

  task automatic chk(input bit ok, input string req_s, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req_s, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", checks + ca + cb, bad + ba + bb);
  endtask

  // driver: waits for idle, issues one request, pushes the expectation
  task automatic do_write(input int i, input logic [15:0] a, input logic [7:0] d);
    while (busy[i]) @(negedge clk);
    req[i] = 1'b1; addr[i] = a; data[i] = d;
    if (i == 0) u_mon_a.push(a, d); else u_mon_b.push(a, d);
    @(negedge clk);
    req[i] = 1'b0; addr[i] = ~a; data[i] = ~d;
    chk(busy[i] == 1'b1, "R2 busy after request", int'(busy[i]), 1);
    chk(sa[i] == a, "R2 address on pins", int'(sa[i]), int'(a));
    chk(done[i] == 1'b0, "R9 done lasts one cycle", int'(done[i]), 0);
  endtask

  task automatic ignore_test(input int i, input logic [15:0] a, input logic [7:0] d);
    do_write(i, a, d);
    for (int k = 0; k < 4; k++) begin
      req[i] = 1'b1; addr[i] = 16'hDEAD; data[i] = 8'hEE;
      @(negedge clk);
    end
    req[i] = 1'b0;
    while (busy[i]) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(busy[i] == 1'b0, "R8 no extra cycle", int'(busy[i]), 0);
    chk(sa[i] == a, "R8 address kept", int'(sa[i]), int'(a));
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      req[i] = 1'b0; addr[i] = '0; data[i] = '0;
    end
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      chk(ce_n[i] && we_n[i] && oe_n[i], "R1 strobes high in reset",
          int'({ce_n[i], we_n[i], oe_n[i]}), 7);
      chk(!dq_oe[i] && !busy[i] && !done[i], "R1 idle in reset",
          int'({dq_oe[i], busy[i], done[i]}), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R3 single writes, write-enable style
    do_write(0, 16'h0000, 8'hA5);
    do_write(0, 16'hFFFF, 8'h5A);
    do_write(0, 16'h1234, 8'h00);
    // R9 back-to-back
    for (int k = 0; k < 4; k++) do_write(0, 16'h4000 + 16'(k), 8'(8'h81 + k));
    ignore_test(0, 16'h0F0F, 8'h3C);

    // R4 / R10 chip-enable style, slow grade
    do_write(1, 16'hA5A5, 8'hFF);
    do_write(1, 16'h5A5A, 8'h01);
    for (int k = 0; k < 3; k++) do_write(1, 16'h8000 - 16'(k), 8'(8'h40 + k));
    ignore_test(1, 16'hC3C3, 8'h99);

    // both at once
    fork
      do_write(0, 16'h7777, 8'h77);
      do_write(1, 16'h8888, 8'h88);
    join
    while (busy[0] || busy[1]) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(pa == 0, "R8 all writes seen (we)", pa, 0);
    chk(pb == 0, "R8 all writes seen (ce)", pb, 0);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule